// File: doc/BRIEF.md
# Supply Power-Fail Warning Controller

This block is the digital control around an analog supply comparator. It receives the supply voltage as an 8-bit code in steps of 10 mV and holds a small configuration register with an enable bit and a 4-bit threshold code. From these it keeps a "supply low" state with hysteresis. When that state is entered, it raises a sticky warning event and an optional interrupt request. While the state holds, it drives an inhibit that blocks writes to non-volatile memory.

The warning is raised by one mechanism, which is entry into the low state. That entry can be caused by a falling supply, by enabling the comparator while the supply is already below the threshold, or by reprogramming the threshold above the present supply. The comparator is gated off while the high-frequency clock is stopped or the system is in its OFF state. The block never requests a reset.

All pins are plain control and status signals sampled on `clk`. There is no streaming interface, so no back-pressure applies.

Top module: `pwr_fail_warn`

## Requirements
- R1: After reset the configuration reads 0, and `warn_evt`, `irq` and `nvm_wr_inhibit` are all 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` on the next clock edge. Bit 0 is the enable and bits 4:1 are the threshold code. `cfg_rdata` returns the stored value.
- R3: A threshold code c of 4 to 15 selects a level of 170 + 10*(c-4) supply units, which is 1.70 V to 2.80 V. Codes 0 to 3 select 170. The supply counts as low only when it is strictly below the level.
- R4: While the comparator is active, a supply that drops below the level sets `warn_evt` and `nvm_wr_inhibit` at the first clock edge that samples the low supply.
- R5: Enabling the comparator while the supply is already below the level raises `warn_evt`.
- R6: Raising the threshold code to a level above the present supply raises `warn_evt`.
- R7: Once low, the state and `nvm_wr_inhibit` persist until the supply exceeds the level plus HYST units (default 5, which is 50 mV). A supply equal to the level plus HYST keeps the state low.
- R8: `warn_evt` stays set until an `evt_clr` pulse. After the clear it is not raised again until the low state has been left through hysteresis and entered again. If a new entry coincides with a clear, the entry wins.
- R9: While `hfclk_on` is 0 or `sys_off` is 1, the comparator is inactive. It produces no event and no inhibit, and any low state is dropped. When it becomes active again with the supply still low, a new event is raised.
- R10: `irq` is high exactly when `warn_evt` and `irq_en` are both high.
- R11: With the enable bit at 0, no supply level produces an event or an inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data: bit 0 is the enable, bits 4:1 are the threshold code |
| cfg_rdata | output | 5 | Stored configuration |
| supply_lvl | input | 8 | Quantized supply voltage in 10 mV units |
| hfclk_on | input | 1 | High-frequency clock running |
| sys_off | input | 1 | System in the OFF state |
| evt_clr | input | 1 | Software clear of the warning event |
| irq_en | input | 1 | Interrupt enable for the warning |
| warn_evt | output | 1 | Sticky power-fail warning event |
| irq | output | 1 | Interrupt request |
| nvm_wr_inhibit | output | 1 | Blocks non-volatile memory writes while the supply is low |

## Verification
The comparator is driven with several distinct patterns, and each one separates one cause of the warning from the others:
- A supply that steps down across a fixed level, sampled at exactly the level and one unit below it, checks the strict comparison and the code decode, including the clamped codes.
- Enabling the comparator into an already low supply, and raising the threshold past a steady supply, show that entry into the low state alone triggers the event, whatever caused it.
- A supply that rises through the hysteresis band, checked at the band edge and one unit above it, shows when the inhibit is released.
- Repeated dips with and without clears separate the sticky and re-arm behaviour.
- Clock-stopped and OFF windows confirm the gating and the fresh event when the comparator wakes.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              en;
  } pfw_cfg_t;
endpackage

// File: rtl/pfw_cfg_reg.sv
module pfw_cfg_reg
  import pfw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  pfw_cfg_t   wdata,
  output pfw_cfg_t   cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) cfg <= wdata;
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg == $past(wdata)));
endmodule

// File: rtl/pfw_thresh.sv
module pfw_thresh #(
  parameter int CODE_W   = 4,
  parameter int LVL_W    = 10,
  parameter int MIN_CODE = 4,
  parameter int BASE     = 170,
  parameter int STEP     = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  level
);
  localparam logic [CODE_W-1:0] MIN_C = CODE_W'(MIN_CODE);
  logic [CODE_W-1:0] eff;

  always_comb begin
    eff   = (code < MIN_C) ? MIN_C : code;
    level = LVL_W'(BASE) + LVL_W'(STEP) * (LVL_W'(eff) - LVL_W'(MIN_CODE));
  end
endmodule

// File: rtl/pfw_hyst_cmp.sv
module pfw_hyst_cmp #(
  parameter int SUP_W = 8,
  parameter int LVL_W = 10,
  parameter int HYST  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SUP_W-1:0] supply,
  input  logic [LVL_W-1:0] thr,
  output logic             low_q,
  output logic             low_rise
);
  logic [LVL_W-1:0] sup_ext;
  logic [LVL_W-1:0] hi_lvl;
  logic             below;
  logic             above;
  logic             low_d;

  always_comb begin
    sup_ext  = LVL_W'(supply);
    hi_lvl   = thr + LVL_W'(HYST);
    below    = sup_ext < thr;
    above    = sup_ext > hi_lvl;
    if (!active)    low_d = 1'b0;
    else if (low_q) low_d = !above;
    else            low_d = below;
    low_rise = low_d && !low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_d;
  end

  // R7
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && low_q && (sup_ext <= hi_lvl)) |=> low_q);

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !low_q);
endmodule

// File: rtl/pfw_event.sv
module pfw_event (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic clr,
  input  logic irq_en,
  output logic evt_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   evt_q <= 1'b0;
    else if (rise) evt_q <= 1'b1;
    else if (clr)  evt_q <= 1'b0;
  end

  assign irq = evt_q && irq_en;

  // R4
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> evt_q);

  // R8
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !clr) |=> evt_q);
endmodule

// File: rtl/pwr_fail_warn.sv
module pwr_fail_warn
  import pfw_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int HYST     = 5,
  parameter int MIN_CODE = 4,
  parameter int BASE     = 170,
  parameter int STEP     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W:0]   cfg_wdata,
  output logic [CODE_W:0]   cfg_rdata,
  input  logic [SUP_W-1:0]  supply_lvl,
  input  logic              hfclk_on,
  input  logic              sys_off,
  input  logic              evt_clr,
  input  logic              irq_en,
  output logic              warn_evt,
  output logic              irq,
  output logic              nvm_wr_inhibit
);
  localparam int LVL_W = SUP_W + 2;

  pfw_cfg_t         cfg;
  logic [LVL_W-1:0] thr;
  logic             active;
  logic             low_q;
  logic             low_rise;

  pfw_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (pfw_cfg_t'(cfg_wdata)),
    .cfg   (cfg)
  );

  pfw_thresh #(
    .CODE_W   (CODE_W),
    .LVL_W    (LVL_W),
    .MIN_CODE (MIN_CODE),
    .BASE     (BASE),
    .STEP     (STEP)
  ) u_thr (
    .code  (cfg.code),
    .level (thr)
  );

  assign active = cfg.en && hfclk_on && !sys_off;

  pfw_hyst_cmp #(
    .SUP_W (SUP_W),
    .LVL_W (LVL_W),
    .HYST  (HYST)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .supply   (supply_lvl),
    .thr      (thr),
    .low_q    (low_q),
    .low_rise (low_rise)
  );

  pfw_event u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (low_rise),
    .clr    (evt_clr),
    .irq_en (irq_en),
    .evt_q  (warn_evt),
    .irq    (irq)
  );

  assign cfg_rdata      = cfg;
  assign nvm_wr_inhibit = low_q;

  // R11
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !nvm_wr_inhibit);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (warn_evt && irq_en));
endmodule

// File: tb/pwr_fail_warn_tb.sv
module pwr_fail_warn_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic [7:0] supply_lvl = 8'd250;
  logic       hfclk_on = 1'b1;
  logic       sys_off = 1'b0;
  logic       evt_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       warn_evt;
  logic       irq;
  logic       nvm_wr_inhibit;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_fail_warn u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .supply_lvl     (supply_lvl),
    .hfclk_on       (hfclk_on),
    .sys_off        (sys_off),
    .evt_clr        (evt_clr),
    .irq_en         (irq_en),
    .warn_evt       (warn_evt),
    .irq            (irq),
    .nvm_wr_inhibit (nvm_wr_inhibit)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit en, input int code);
    cfg_wdata = {4'(code), en};
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_evt();
    evt_clr = 1'b1;
    tick(1);
    evt_clr = 1'b0;
  endtask

  task automatic baseline();
    supply_lvl = 8'd250;
    hfclk_on = 1'b1;
    sys_off = 1'b0;
    irq_en = 1'b0;
    cfg_write(1'b0, 0);
    clear_evt();
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1 cfg", int'(cfg_rdata), 0);
    chk("R1 evt", int'(warn_evt), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 inhibit", int'(nvm_wr_inhibit), 0);
  endtask

  task automatic t_cfg();
    baseline();
    cfg_write(1'b1, 11);
    tick(1);
    chk("R2 readback", int'(cfg_rdata), 23);
    cfg_write(1'b0, 6);
    tick(1);
    chk("R2 readback2", int'(cfg_rdata), 12);
  endtask

  task automatic t_fall();
    baseline();
    cfg_write(1'b1, 9);           // level 220
    supply_lvl = 8'd220; tick(3);
    chk("R3 at level not low", int'(warn_evt), 0);
    supply_lvl = 8'd219; tick(1);
    chk("R4 evt after fall", int'(warn_evt), 1);
    chk("R4 inhibit after fall", int'(nvm_wr_inhibit), 1);
  endtask

  task automatic t_map();
    baseline();
    cfg_write(1'b1, 0);           // clamps to 170
    supply_lvl = 8'd170; tick(3);
    chk("R3 code0 at 170", int'(warn_evt), 0);
    supply_lvl = 8'd169; tick(2);
    chk("R3 code0 at 169", int'(warn_evt), 1);
    baseline();
    supply_lvl = 8'd250;
    cfg_write(1'b1, 15);          // 280, above any 8-bit supply
    tick(2);
    chk("R3 code15", int'(nvm_wr_inhibit), 1);
  endtask

  task automatic t_enable_low();
    baseline();
    supply_lvl = 8'd180;
    cfg_write(1'b0, 8);           // 210, disabled
    tick(3);
    chk("R11 disabled low", int'(warn_evt), 0);
    chk("R11 disabled inhibit", int'(nvm_wr_inhibit), 0);
    cfg_write(1'b1, 8);
    tick(2);
    chk("R5 enable into low", int'(warn_evt), 1);
  endtask

  task automatic t_raise();
    baseline();
    supply_lvl = 8'd200;
    cfg_write(1'b1, 4);
    tick(3);
    chk("R6 below old level", int'(warn_evt), 0);
    cfg_write(1'b1, 8);           // 210 > 200
    tick(2);
    chk("R6 raised threshold", int'(warn_evt), 1);
  endtask

  task automatic t_hyst();
    baseline();
    cfg_write(1'b1, 9);           // 220, release above 225
    supply_lvl = 8'd200; tick(2);
    supply_lvl = 8'd222; tick(3);
    chk("R7 inside band", int'(nvm_wr_inhibit), 1);
    supply_lvl = 8'd225; tick(3);
    chk("R7 at band edge", int'(nvm_wr_inhibit), 1);
    supply_lvl = 8'd226; tick(2);
    chk("R7 released", int'(nvm_wr_inhibit), 0);
  endtask

  task automatic t_sticky();
    baseline();
    cfg_write(1'b1, 9);
    supply_lvl = 8'd200; tick(2);
    supply_lvl = 8'd240; tick(3);
    chk("R8 sticky after recovery", int'(warn_evt), 1);
    supply_lvl = 8'd200; tick(2);
    clear_evt(); tick(4);
    chk("R8 no refire while low", int'(warn_evt), 0);
    supply_lvl = 8'd223; tick(3);
    chk("R8 no refire in band", int'(warn_evt), 0);
    supply_lvl = 8'd230; tick(2);
    supply_lvl = 8'd210; tick(2);
    chk("R8 rearmed", int'(warn_evt), 1);
    // entry coincident with clear: entry wins
    supply_lvl = 8'd230; tick(2);
    clear_evt(); tick(1);
    supply_lvl = 8'd210; evt_clr = 1'b1; tick(1); evt_clr = 1'b0;
    tick(1);
    chk("R8 set beats clear", int'(warn_evt), 1);
  endtask

  task automatic t_gate();
    baseline();
    hfclk_on = 1'b0;
    cfg_write(1'b1, 9);
    supply_lvl = 8'd150; tick(3);
    chk("R9 clock stopped evt", int'(warn_evt), 0);
    chk("R9 clock stopped inhibit", int'(nvm_wr_inhibit), 0);
    hfclk_on = 1'b1; tick(2);
    chk("R9 wake evt", int'(warn_evt), 1);
    clear_evt();
    sys_off = 1'b1; tick(2);
    chk("R9 off inhibit", int'(nvm_wr_inhibit), 0);
    chk("R9 off evt", int'(warn_evt), 0);
    sys_off = 1'b0; tick(2);
    chk("R9 back on evt", int'(warn_evt), 1);
  endtask

  task automatic t_irq();
    baseline();
    cfg_write(1'b1, 9);
    supply_lvl = 8'd200; tick(2);
    chk("R10 masked", int'(irq), 0);
    irq_en = 1'b1; #1;
    chk("R10 enabled", int'(irq), 1);
    clear_evt(); #1;
    chk("R10 cleared", int'(irq), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_cfg();
    t_fall();
    t_map();
    t_enable_low();
    t_raise();
    t_hyst();
    t_sticky();
    t_gate();
    t_irq();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule